// File: doc/BRIEF.md
# NAND Hamming ECC accumulator

This block builds a single-error-correcting Hamming parity over a block of bytes while they stream between a memory controller and a NAND device. Before it accumulates anything, a chip select must claim the engine. The claim fixes the owning chip select, the data width (8-bit or 16-bit) and the block length. The length is programmed as half the byte count minus one, so the default 8-bit field covers blocks of 2 to 512 bytes.

Each accepted byte adds to 12 even and 12 odd parity bits:

- The three column pairs (P1, P2, P4) are taken over the bit positions inside a byte.
- The nine row pairs (P8 to P2048) are taken over the byte index.

The parity is kept non-inverted. Accumulation stops by itself once the programmed number of bytes has arrived. A read by the owning chip select returns the packed 3-byte code and releases the engine for the next claimant.

The control state machine has three states:

- `ST_FREE`: no owner.
- `ST_ACCUM`: owned and accepting data.
- `ST_DONE`: owned, block complete, data ignored.

The transitions are:

- *claim*: `ST_FREE` to `ST_ACCUM`.
- *block end*: `ST_ACCUM` to `ST_DONE`, on the last byte.
- *restart*: `ST_ACCUM` or `ST_DONE` to `ST_ACCUM`, on `clr`.
- *release*: `ST_ACCUM` or `ST_DONE` to `ST_FREE`, on a read by the owner.

Top module: `nand_ecc_acc`

## Requirements
- R1: A claim (`claim_valid`) while no chip select owns the engine has these effects one cycle later: `claim_ack` is 1, `busy` is 1, `owner_cs` equals `claim_cs`, and `res_word` is zero. The same claim latches `claim_wide` and `claim_size`.
- R2: A claim while `busy` is 1 gives `claim_nack` = 1 and `claim_ack` = 0 one cycle later. It leaves `owner_cs`, the configuration and the accumulated parity unchanged.
- R3: Column parity works on the bit positions j = 0..7 of each byte. Even bit k (k = 0,1,2 for P1, P2, P4) is the XOR, over all accepted bytes, of the bits whose position j has bit k clear. Odd bit k is the XOR of the bits whose position has bit k set.
- R4: Row parity works on the byte index i inside the block. Even bit 3+r (r = 0..8 for P8 to P2048) is the XOR of the parity of every accepted byte whose index i has bit r clear. Odd bit 3+r is the same XOR over the bytes whose index has bit r set.
- R5: `res_word` holds the even bits P1..P128 at [7:0] and P256..P2048 at [11:8]. It holds the odd bits P1..P128 at [23:16] and P256..P2048 at [27:24]. All other bits read 0.
- R6: A read (`rd_req`) whose `rd_cs` equals the owner, while `busy` is 1, has these effects one cycle later: `rd_valid` is 1, `busy` is 0, and `rd_code` holds the code at the time of the read. The code layout is `rd_code[7:0]` = `res_word[7:0]`, `rd_code[15:8]` = `res_word[23:16]`, and `rd_code[23:16]` = {`res_word[27:24]`, `res_word[11:8]`}. A read by any other chip select, or a read while free, gives no `rd_valid` and changes nothing.
- R7: The parity is not inverted, so a full block of 0xFF bytes yields an all-zero code.
- R8: A data cycle counts only when `dat_valid` = 1, `en` = 1 and the state is `ST_ACCUM`. Any other cycle leaves `res_word` unchanged.
- R9: The block holds 2*(`claim_size`+1) bytes. After the last byte is accepted, `done` is 1 and further data leaves `res_word` unchanged.
- R10: In 16-bit mode (`claim_wide` = 1), each accepted word supplies two bytes. `dat[7:0]` is the byte at the even index i and `dat[15:8]` is the byte at i+1. In 8-bit mode only `dat[7:0]` is used.
- R11: `clr` zeroes `res_word` one cycle later, resets the byte index and clears `done`. An owned engine then accepts a fresh block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| claim_valid | input | 1 | Request to take ownership |
| claim_cs | input | CS_W | Chip select making the claim |
| claim_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| claim_size | input | SIZE_W | Block length as bytes/2 - 1 |
| claim_ack | output | 1 | Claim granted (registered pulse) |
| claim_nack | output | 1 | Claim refused because the engine is owned (registered pulse) |
| busy | output | 1 | Engine is owned |
| owner_cs | output | CS_W | Current owning chip select |
| clr | input | 1 | Clear accumulated parity and restart the block |
| en | input | 1 | Accumulation enable |
| dat_valid | input | 1 | Data word present |
| dat | input | 16 | Data; the low byte comes first in 16-bit mode |
| done | output | 1 | Programmed block length reached |
| res_word | output | 32 | Packed live result |
| rd_req | input | 1 | Read the code and release ownership |
| rd_cs | input | CS_W | Chip select issuing the read |
| rd_valid | output | 1 | Read granted (registered pulse) |
| rd_code | output | 2*SIZE_W+8 | Three-byte code captured at the read |

## Verification
`claim_ack`, `claim_nack`, `rd_valid`, `rd_code`, `busy`, `owner_cs` and `done` all change at the first rising edge after the cycle that requests them. `res_word` shows an accepted byte or a clear after that same single edge. The bench therefore drives every input on the falling edge and samples the outputs on the following falling edge, exactly one register stage later. Expected codes come from a per-bit reference model in the bench: each set data bit toggles even or odd parity according to the bits of its combined byte-and-bit address. That model is written independently of the byte-wise formulation used in the RTL.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DONE  = 2'd2
    } own_state_t;

endpackage

// File: rtl/ecc_byte_term.sv
// Parity contribution of one byte at a given index within the block.
module ecc_byte_term #(
    parameter int ROW_BITS = 9,
    localparam int NPAR = ROW_BITS + 3
) (
    input  logic                 active_i,
    input  logic [7:0]           byte_i,
    input  logic [ROW_BITS-1:0]  idx_i,
    output logic [NPAR-1:0]      even_o,
    output logic [NPAR-1:0]      odd_o
);
    logic bpar;

    always_comb begin
        even_o = '0;
        odd_o  = '0;
        bpar   = ^byte_i;
        if (active_i) begin
            // column terms: bit position split by address bits 0..2
            for (int k = 0; k < 3; k++) begin
                for (int j = 0; j < 8; j++) begin
                    if (((j >> k) & 1) != 0)
                        odd_o[k] = odd_o[k] ^ byte_i[j];
                    else
                        even_o[k] = even_o[k] ^ byte_i[j];
                end
            end
            // row terms: byte parity split by byte index bits
            for (int r = 0; r < ROW_BITS; r++) begin
                if (idx_i[r])
                    odd_o[r+3] = bpar;
                else
                    even_o[r+3] = bpar;
            end
        end
    end

endmodule

// File: rtl/ecc_own_fsm.sv
// Ownership, block length and byte index control.
module ecc_own_fsm
    import nand_ecc_pkg::*;
#(
    parameter int CS_W   = 3,
    parameter int SIZE_W = 8,
    localparam int TOT_W    = SIZE_W + 2,
    localparam int ROW_BITS = SIZE_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 claim_valid,
    input  logic [CS_W-1:0]      claim_cs,
    input  logic                 claim_wide,
    input  logic [SIZE_W-1:0]    claim_size,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 dat_valid,
    input  logic                 rd_req,
    input  logic [CS_W-1:0]      rd_cs,
    output logic                 claim_ack,
    output logic                 claim_nack,
    output logic                 busy,
    output logic [CS_W-1:0]      owner_cs,
    output logic                 done,
    output logic                 rd_valid,
    output logic                 accept_o,
    output logic                 wide_o,
    output logic                 clear_o,
    output logic                 rd_fire_o,
    output logic [ROW_BITS-1:0]  idx_o
);
    own_state_t state_q, state_d;

    logic [CS_W-1:0]   owner_q;
    logic              wide_q;
    logic [SIZE_W-1:0] size_q;
    logic [TOT_W-1:0]  idx_q;
    logic [TOT_W-1:0]  total;
    logic [TOT_W-1:0]  step;
    logic              claim_fire;
    logic              rd_fire;
    logic              accept;
    logic              last_unit;
    logic              ack_q, nack_q, rdv_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    // next state and decoded controls
    always_comb begin
        total      = ({2'b00, size_q} + TOT_W'(1)) << 1;
        step       = wide_q ? TOT_W'(2) : TOT_W'(1);
        claim_fire = claim_valid && (state_q == ST_FREE);
        rd_fire    = rd_req && (state_q != ST_FREE) && (rd_cs == owner_q);
        accept     = dat_valid && en && (state_q == ST_ACCUM) && !clr && !rd_fire;
        last_unit  = accept && ((idx_q + step) == total);
        state_d    = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (claim_fire) state_d = ST_ACCUM;
            end
            ST_ACCUM: begin
                if (rd_fire)        state_d = ST_FREE;
                else if (clr)       state_d = ST_ACCUM;
                else if (last_unit) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (rd_fire)  state_d = ST_FREE;
                else if (clr) state_d = ST_ACCUM;
            end
            default: state_d = ST_FREE;
        endcase
    end

    // configuration, index and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_q <= '0;
            wide_q  <= 1'b0;
            size_q  <= '0;
            idx_q   <= '0;
            ack_q   <= 1'b0;
            nack_q  <= 1'b0;
            rdv_q   <= 1'b0;
        end else begin
            if (claim_fire) begin
                owner_q <= claim_cs;
                wide_q  <= claim_wide;
                size_q  <= claim_size;
            end
            if (claim_fire || clr) idx_q <= '0;
            else if (accept)       idx_q <= idx_q + step;
            ack_q  <= claim_fire;
            nack_q <= claim_valid && (state_q != ST_FREE);
            rdv_q  <= rd_fire;
        end
    end

    assign claim_ack  = ack_q;
    assign claim_nack = nack_q;
    assign rd_valid   = rdv_q;
    assign busy       = (state_q != ST_FREE);
    assign done       = (state_q == ST_DONE);
    assign owner_cs   = owner_q;
    assign accept_o   = accept;
    assign wide_o     = wide_q;
    assign clear_o    = claim_fire || clr;
    assign rd_fire_o  = rd_fire;
    assign idx_o      = idx_q[ROW_BITS-1:0];

    AST_NACK_WHEN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_valid && busy) |=> (claim_nack && !claim_ack)); // R2
    AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(owner_cs)); // R2
    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy); // R6
    AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        claim_ack |-> busy); // R1

endmodule

// File: rtl/nand_ecc_acc.sv
// Top: parity accumulators, packing and read capture.
module nand_ecc_acc
    import nand_ecc_pkg::*;
#(
    parameter int CS_W   = 3,
    parameter int SIZE_W = 8,   // 5..11 supported by the 32-bit result packing
    localparam int ROW_BITS = SIZE_W + 1,
    localparam int NPAR     = ROW_BITS + 3,
    localparam int HI       = NPAR - 8,
    localparam int CODE_W   = 2 * NPAR,
    localparam int LANES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 claim_valid,
    input  logic [CS_W-1:0]      claim_cs,
    input  logic                 claim_wide,
    input  logic [SIZE_W-1:0]    claim_size,
    output logic                 claim_ack,
    output logic                 claim_nack,
    output logic                 busy,
    output logic [CS_W-1:0]      owner_cs,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 dat_valid,
    input  logic [15:0]          dat,
    output logic                 done,
    output logic [31:0]          res_word,
    input  logic                 rd_req,
    input  logic [CS_W-1:0]      rd_cs,
    output logic                 rd_valid,
    output logic [CODE_W-1:0]    rd_code
);
    logic                accept, wide, clear_acc, rd_fire;
    logic [ROW_BITS-1:0] idx;
    logic [NPAR-1:0]     even_q, odd_q;
    logic [NPAR-1:0]     lane_even [LANES];
    logic [NPAR-1:0]     lane_odd  [LANES];
    logic [NPAR-1:0]     sum_even, sum_odd;
    logic [CODE_W-1:0]   code_now, code_q;

    ecc_own_fsm #(.CS_W(CS_W), .SIZE_W(SIZE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .claim_valid (claim_valid),
        .claim_cs    (claim_cs),
        .claim_wide  (claim_wide),
        .claim_size  (claim_size),
        .clr         (clr),
        .en          (en),
        .dat_valid   (dat_valid),
        .rd_req      (rd_req),
        .rd_cs       (rd_cs),
        .claim_ack   (claim_ack),
        .claim_nack  (claim_nack),
        .busy        (busy),
        .owner_cs    (owner_cs),
        .done        (done),
        .rd_valid    (rd_valid),
        .accept_o    (accept),
        .wide_o      (wide),
        .clear_o     (clear_acc),
        .rd_fire_o   (rd_fire),
        .idx_o       (idx)
    );

    // one byte term per lane; lane 1 only in 16-bit mode
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic lane_act;
        assign lane_act = accept && ((l == 0) || wide);
        ecc_byte_term #(.ROW_BITS(ROW_BITS)) u_term (
            .active_i (lane_act),
            .byte_i   (dat[8*l +: 8]),
            .idx_i    (idx + ROW_BITS'(l)),
            .even_o   (lane_even[l]),
            .odd_o    (lane_odd[l])
        );
    end

    always_comb begin
        sum_even = '0;
        sum_odd  = '0;
        for (int l = 0; l < LANES; l++) begin
            sum_even = sum_even ^ lane_even[l];
            sum_odd  = sum_odd  ^ lane_odd[l];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            even_q <= '0;
            odd_q  <= '0;
            code_q <= '0;
        end else begin
            if (clear_acc) begin
                even_q <= '0;
                odd_q  <= '0;
            end else if (accept) begin
                even_q <= even_q ^ sum_even;
                odd_q  <= odd_q  ^ sum_odd;
            end
            if (rd_fire) code_q <= code_now;
        end
    end

    assign res_word = {{(8-HI){1'b0}}, odd_q[NPAR-1:8], odd_q[7:0],
                       {(8-HI){1'b0}}, even_q[NPAR-1:8], even_q[7:0]};
    assign code_now = {odd_q[NPAR-1:8], even_q[NPAR-1:8], odd_q[7:0], even_q[7:0]};
    assign rd_code  = code_q;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (res_word == 32'd0)); // R11
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en && !clr) |=> $stable(res_word)); // R8
    AST_HOLD_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> $stable(res_word)); // R9
    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_word[15:12] == 4'd0) && (res_word[31:28] == 4'd0)); // R5

endmodule

// File: tb/nand_ecc_acc_tb.sv
module nand_ecc_acc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        claim_valid = 1'b0;
    logic [2:0]  claim_cs = '0;
    logic        claim_wide = 1'b0;
    logic [7:0]  claim_size = '0;
    logic        claim_ack, claim_nack, busy, done, rd_valid;
    logic [2:0]  owner_cs;
    logic        clr = 1'b0;
    logic        en = 1'b0;
    logic        dat_valid = 1'b0;
    logic [15:0] dat = '0;
    logic [31:0] res_word;
    logic        rd_req = 1'b0;
    logic [2:0]  rd_cs = '0;
    logic [23:0] rd_code;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mem [0:511];

    always #2.5 clk = ~clk;

    nand_ecc_acc u_dut (
        .clk(clk), .rst_n(rst_n),
        .claim_valid(claim_valid), .claim_cs(claim_cs), .claim_wide(claim_wide),
        .claim_size(claim_size), .claim_ack(claim_ack), .claim_nack(claim_nack),
        .busy(busy), .owner_cs(owner_cs), .clr(clr), .en(en),
        .dat_valid(dat_valid), .dat(dat), .done(done), .res_word(res_word),
        .rd_req(rd_req), .rd_cs(rd_cs), .rd_valid(rd_valid), .rd_code(rd_code)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-bit reference: each set bit toggles even/odd by its address bits
    task automatic model(input int n, output logic [31:0] exp_res, output logic [23:0] exp_code);
        logic [11:0] ev = '0;
        logic [11:0] od = '0;
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (mem[i][j]) begin
                    for (int k = 0; k < 12; k++) begin
                        int a = (k < 3) ? ((j >> k) & 1) : ((i >> (k - 3)) & 1);
                        if (a != 0) od[k] = ~od[k];
                        else        ev[k] = ~ev[k];
                    end
                end
            end
        end
        exp_res  = {4'h0, od[11:8], od[7:0], 4'h0, ev[11:8], ev[7:0]};
        exp_code = {od[11:8], ev[11:8], od[7:0], ev[7:0]};
    endtask

    task automatic claim(input logic [2:0] cs, input logic wide, input logic [7:0] sz);
        claim_valid = 1'b1; claim_cs = cs; claim_wide = wide; claim_size = sz;
        @(negedge clk);
        claim_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic e);
        dat_valid = 1'b1; en = e; dat = {8'hA5, b};
        @(negedge clk);
        dat_valid = 1'b0; en = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        dat_valid = 1'b1; en = 1'b1; dat = w;
        @(negedge clk);
        dat_valid = 1'b0; en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] cs);
        rd_req = 1'b1; rd_cs = cs;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "busy after reset", 32'(busy), 32'd0);
        chk("R5", "res_word after reset", res_word, 32'd0);
        chk("R9", "done after reset", 32'(done), 32'd0);
    endtask

    task automatic t_packing();
        claim(3'd2, 1'b0, 8'd0);
        chk("R1", "claim_ack", 32'(claim_ack), 32'd1);
        chk("R1", "owner_cs", 32'(owner_cs), 32'd2);
        chk("R1", "res cleared on claim", res_word, 32'd0);
        send_byte(8'h01, 1'b1);
        chk("R4", "single byte at index 0", res_word, 32'h0000_0FFF);
        send_byte(8'h80, 1'b1);
        chk("R5", "two byte packing", res_word, 32'h000F_000F);
        chk("R9", "done after 2 bytes", 32'(done), 32'd1);
        do_read(3'd2);
        chk("R6", "rd_valid", 32'(rd_valid), 32'd1);
        chk("R6", "rd_code packing", 32'(rd_code), 32'h0000_0F0F);
        chk("R6", "released", 32'(busy), 32'd0);
    endtask

    task automatic t_full_block();
        logic [31:0] er; logic [23:0] ec;
        claim(3'd5, 1'b0, 8'd255);
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'((i * 7 + 3) ^ (i >> 3));
            send_byte(mem[i], 1'b1);
        end
        model(512, er, ec);
        chk("R3", "full 512-byte block", res_word, er);
        chk("R9", "done after 512 bytes", 32'(done), 32'd1);
        send_byte(8'h5A, 1'b1);
        send_byte(8'h33, 1'b1);
        chk("R9", "bytes after block ignored", res_word, er);
        do_read(3'd4);
        chk("R6", "non-owner read no rd_valid", 32'(rd_valid), 32'd0);
        chk("R6", "non-owner read keeps busy", 32'(busy), 32'd1);
        do_read(3'd5);
        chk("R6", "owner read code", 32'(rd_code), 32'(ec));
        chk("R6", "owner read releases", 32'(busy), 32'd0);
    endtask

    task automatic t_erased();
        claim(3'd1, 1'b0, 8'd255);
        for (int i = 0; i < 512; i++) send_byte(8'hFF, 1'b1);
        chk("R7", "erased block result", res_word, 32'd0);
        do_read(3'd1);
        chk("R7", "erased code not all ones", 32'(rd_code == 24'hFFFFFF), 32'd0);
    endtask

    task automatic t_wide();
        logic [31:0] er; logic [23:0] ec;
        claim(3'd3, 1'b1, 8'd3);
        for (int w = 0; w < 4; w++) begin
            mem[2*w]   = 8'(8'h11 * w + 8'h2C);
            mem[2*w+1] = 8'(8'h93 ^ (w << 2));
            send_word({mem[2*w+1], mem[2*w]});
        end
        model(8, er, ec);
        chk("R10", "16-bit block result", res_word, er);
        chk("R10", "16-bit done after 4 words", 32'(done), 32'd1);
        do_read(3'd3);
        chk("R10", "16-bit code", 32'(rd_code), 32'(ec));
    endtask

    task automatic t_gating();
        logic [31:0] er; logic [23:0] ec; logic [31:0] held;
        claim(3'd6, 1'b0, 8'd7);
        for (int i = 0; i < 16; i++) begin
            mem[i] = 8'(i * 29 + 1);
            send_byte(mem[i], 1'b1);
            if (i == 6) begin
                held = res_word;
                send_byte(8'hE7, 1'b0);
                chk("R8", "byte with en low ignored", res_word, held);
                dat_valid = 1'b0; en = 1'b1; dat = 16'h00C3;
                @(negedge clk);
                en = 1'b0;
                chk("R8", "en without valid ignored", res_word, held);
            end
        end
        model(16, er, ec);
        chk("R8", "gated stream result", res_word, er);
        claim(3'd0, 1'b0, 8'd1);
        chk("R2", "claim while owned nacked", 32'(claim_nack), 32'd1);
        chk("R2", "claim while owned no ack", 32'(claim_ack), 32'd0);
        chk("R2", "owner unchanged", 32'(owner_cs), 32'd6);
        chk("R2", "result unchanged by claim", res_word, er);
        do_read(3'd6);
    endtask

    task automatic t_clear();
        logic [31:0] er; logic [23:0] ec;
        claim(3'd7, 1'b0, 8'd3);
        for (int i = 0; i < 5; i++) send_byte(8'(8'hC1 + i), 1'b1);
        pulse_clr();
        chk("R11", "clear zeroes result", res_word, 32'd0);
        chk("R11", "still owned after clear", 32'(busy), 32'd1);
        for (int i = 0; i < 8; i++) begin
            mem[i] = 8'(i * 53 + 9);
            send_byte(mem[i], 1'b1);
        end
        model(8, er, ec);
        chk("R11", "fresh block after clear", res_word, er);
        chk("R11", "done after fresh block", 32'(done), 32'd1);
        pulse_clr();
        chk("R11", "clear leaves done state", 32'(done), 32'd0);
        do_read(3'd7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_packing();
        t_full_block();
        t_erased();
        t_wide();
        t_gating();
        t_clear();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule